// File: doc/BRIEF.md
# Rotating Priority Bus Arbiter

This block decides which of three masters owns a shared internal bus. The masters are a CPU, a DMA engine and a host bridge. The host bridge requests the bus on behalf of external PCI masters, either to drain posted write data or to perform a memory read. Only one master owns the bus at a time. Ownership is reported on a registered one-hot grant vector. Once a master is granted, it keeps the bus until it pulses the transaction-done input. At that edge the block arbitrates again among the requests present, and the new grant is visible in the following cycle.

Priority is an ordered queue. The winner goes to the back of the queue. Any master ahead of the winner that was not requesting is demoted along with it. The resulting queue holds the masters that were behind the winner, then the passed-over masters, then the winner. Because all demotions preserve cyclic order, the queue is always a rotation of index order and is stored as a head pointer. When no master requests, the grant is parked on the CPU and the queue stays unchanged. The CPU is also the owner out of reset.

Top module: `rot_bus_arbiter`

## Requirements
- R1: `gnt_o` has exactly one bit set in every cycle after reset.
- R2: After reset, `gnt_o` selects the CPU (bit 0), and the queue order, from highest priority, is CPU (0), DMA (1), bridge (2).
- R3: When the bus is free and no master requests, the next cycle grants the CPU (bit 0) and leaves the queue order unchanged.
- R4: While a master holds a transaction (granted and `done_i` low), `gnt_o` and the queue stay unchanged, whatever `req_i` does.
- R5: On an arbitration edge with any request, the grant goes to the requesting master that sits nearest the front of the queue.
- R6: After a win, the queue head becomes the master at index (winner+1) mod 3. The winner and every passed-over idle master move behind the masters that were queued after the winner.
- R7: A parked grant leaves the CPU in the cycle after another master requests, unless the CPU itself requests and is ahead in the queue.
- R8: Starting from reset, a lone CPU request followed by CPU and bridge requests, and then all three requests with `done_i` high, produces grants in the order 0, 2, 0, 1, 2, 0, 1, 2.
- R9: `done_i` has no effect while the bus is parked with no request: the grant stays on the CPU and the queue is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_MST | Request per master: bit 0 CPU, bit 1 DMA, bit 2 host bridge |
| done_i | input | 1 | Current owner has finished its transaction |
| gnt_o | output | NUM_MST | Registered one-hot grant, same bit order as req_i |

## Verification
The assertions check the following on every cycle: that the grant is one-hot, that grant and queue hold during a transaction, that an idle arbitration parks on the CPU without moving the queue, that a granted master was requesting, and that the new queue head follows the winner. The claims that the winner is the first requester in queue order, that passed-over masters are demoted, and that the stated eight-grant order holds can only be shown by the bench. The bench does this with an exhaustive sweep over every queue position and request pattern, using an arithmetic reference model, and with a directed rotation scenario.

// File: rtl/rba_pkg.sv
package rba_pkg;
  // (a + 1) mod n for small index values
  function automatic int unsigned wrap_inc(int unsigned a, int unsigned n);
    return (a + 1 >= n) ? 0 : a + 1;
  endfunction
endpackage

// File: rtl/rba_pick.sv
module rba_pick #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] head_i,
  output logic          win_vld_o,
  output logic [IW-1:0] win_idx_o
);
  // scan from lowest priority to highest so the front-most requester wins
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int unsigned pos;
      pos = int'(head_i) + k;
      if (pos >= N) pos = pos - N;
      if (req_i[pos]) begin
        win_vld_o = 1'b1;
        win_idx_o = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/rba_queue.sv
module rba_queue #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [IW-1:0] win_idx_i,
  output logic [IW-1:0] head_o
);
  import rba_pkg::*;
  logic [IW-1:0] head_q;
  logic [IW-1:0] head_nxt;

  // winner and skipped entries go behind the rest: head = winner + 1
  assign head_nxt = IW'(wrap_inc(int'(win_idx_i), N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    head_q <= '0;
    else if (adv_i) head_q <= head_nxt;
  end

  assign head_o = head_q;
endmodule

// File: rtl/rba_owner.sv
module rba_owner #(
  parameter int unsigned N        = 3,
  parameter int unsigned PARK_IDX = 0,
  parameter int unsigned IW       = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          win_vld_i,
  input  logic [IW-1:0] win_idx_i,
  output logic          take_o,
  output logic          busy_o,
  output logic [N-1:0]  gnt_o
);
  localparam logic [N-1:0] PARK_GNT = N'(1) << PARK_IDX;

  logic         busy_q;
  logic [N-1:0] gnt_q;
  logic         arb_en;

  assign arb_en = !busy_q || done_i;
  assign take_o = arb_en && win_vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      gnt_q  <= PARK_GNT;
    end else if (arb_en) begin
      if (win_vld_i) begin
        busy_q <= 1'b1;
        gnt_q  <= N'(1) << win_idx_i;
      end else begin
        busy_q <= 1'b0;
        gnt_q  <= PARK_GNT;
      end
    end
  end

  assign busy_o = busy_q;
  assign gnt_o  = gnt_q;
endmodule

// File: rtl/rot_bus_arbiter.sv
module rot_bus_arbiter #(
  parameter int unsigned NUM_MST  = 3,
  parameter int unsigned PARK_IDX = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_MST-1:0] req_i,
  input  logic               done_i,
  output logic [NUM_MST-1:0] gnt_o
);
  localparam int unsigned IW = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;

  logic [IW-1:0] head;
  logic [IW-1:0] win_idx;
  logic          win_vld;
  logic          take;
  logic          busy;

  rba_pick #(.N(NUM_MST), .IW(IW)) i_pick (
    .req_i     (req_i),
    .head_i    (head),
    .win_vld_o (win_vld),
    .win_idx_o (win_idx)
  );

  rba_queue #(.N(NUM_MST), .IW(IW)) i_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (take),
    .win_idx_i (win_idx),
    .head_o    (head)
  );

  rba_owner #(.N(NUM_MST), .PARK_IDX(PARK_IDX), .IW(IW)) i_owner (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done_i),
    .win_vld_i (win_vld),
    .win_idx_i (win_idx),
    .take_o    (take),
    .busy_o    (busy),
    .gnt_o     (gnt_o)
  );
endmodule

// File: rtl/rba_checker.sv
module rba_checker #(
  parameter int unsigned N        = 3,
  parameter int unsigned PARK_IDX = 0,
  parameter int unsigned IW       = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  req_i,
  input logic          done_i,
  input logic [N-1:0]  gnt_o,
  input logic          busy_i,
  input logic [IW-1:0] head_i
);
  localparam logic [N-1:0] PARK_GNT = N'(1) << PARK_IDX;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gnt_o) == 1); // R1

  AST_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i |=> $stable(gnt_o) && $stable(head_i)); // R4

  AST_PARK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i || done_i) && req_i == '0 |=> gnt_o == PARK_GNT && $stable(head_i)); // R3

  AST_GNT_TO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i || done_i) && req_i != '0 |=> (gnt_o & $past(req_i)) != '0); // R5

  AST_WINNER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i || done_i) && req_i != '0 |=> gnt_o[(int'(head_i) + N - 1) % N]); // R6

  AST_PARK_DONE_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && done_i && req_i == '0 |=> !busy_i && gnt_o == PARK_GNT); // R9
endmodule

bind rot_bus_arbiter rba_checker #(.N(NUM_MST), .PARK_IDX(PARK_IDX)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .done_i (done_i),
  .gnt_o  (gnt_o),
  .busy_i (busy),
  .head_i (head)
);

// File: tb/test_rot_bus_arbiter.sv
module test_rot_bus_arbiter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] req_i = '0;
  logic       done_i = 1'b0;
  logic [2:0] gnt_o;

  int n_chk = 0;
  int n_err = 0;
  bit fin = 0;

  // reference model
  int  m_head = 0;
  int  m_own  = 0;
  bit  m_busy = 0;

  always #10 clk_i = ~clk_i;

  rot_bus_arbiter i_rot_bus_arbiter (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req_i),
    .done_i (done_i), .gnt_o (gnt_o)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: gnt_o=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] r, input logic d);
    if (!m_busy || d) begin
      if (r == 3'b000) begin
        m_own = 0; m_busy = 0;
      end else begin
        for (int k = 2; k >= 0; k--)
          if (r[(m_head + k) % 3]) m_own = (m_head + k) % 3;
        m_head = (m_own + 1) % 3;
        m_busy = 1;
      end
    end
  endtask

  task automatic step(input logic [2:0] r, input logic d, input string tag);
    req_i = r; done_i = d;
    model(r, d);
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag, gnt_o, 3'b001 << m_own);
    n_chk++;
    if ($countones(gnt_o) != 1) begin
      n_err++;
      $display("FAIL R1: gnt_o=%b expected one-hot", gnt_o);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = '0; done_i = 1'b0;
    m_head = 0; m_own = 0; m_busy = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  int seq_exp[8] = '{0, 2, 0, 1, 2, 0, 1, 2};

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R2 reset", gnt_o, 3'b001);
    step(3'b111, 1'b0, "R2 first winner");

    // R8 rotation example
    do_reset();
    step(3'b001, 1'b1, "R8 seq");
    check("R8 order", gnt_o, 3'b001 << seq_exp[0]);
    step(3'b101, 1'b1, "R8 seq");
    check("R8 order", gnt_o, 3'b001 << seq_exp[1]);
    for (int i = 2; i < 8; i++) begin
      step(3'b111, 1'b1, "R8 seq");
      check("R8 order", gnt_o, 3'b001 << seq_exp[i]);
    end

    // R4 hold against changing requests
    do_reset();
    step(3'b010, 1'b0, "R5 grant dma");
    check("R4 held", gnt_o, 3'b010);
    step(3'b101, 1'b0, "R4 hold");
    step(3'b000, 1'b0, "R4 hold");
    check("R4 still dma", gnt_o, 3'b010);
    step(3'b100, 1'b1, "R4 release to bridge");

    // R3 park, R9 done while parked, R7 leave park
    step(3'b000, 1'b1, "R3 park");
    check("R3 cpu parked", gnt_o, 3'b001);
    step(3'b000, 1'b1, "R9 done ignored");
    step(3'b000, 1'b0, "R3 park stays");
    step(3'b111, 1'b0, "R9 queue unchanged");
    check("R9 head after bridge is cpu", gnt_o, 3'b001);
    step(3'b000, 1'b1, "R3 park");
    step(3'b010, 1'b0, "R7 leave park");
    check("R7 dma from park", gnt_o, 3'b010);

    // exhaustive sweep: every head position x every request pattern
    for (int h = 0; h < 3; h++) begin
      for (int p = 0; p < 8; p++) begin
        do_reset();
        step(3'b001 << ((h + 2) % 3), 1'b0, "R6 set head");
        step(3'(p), 1'b1, "R5 R6 sweep pick");
        step(3'b111, 1'b1, "R6 sweep next");
        step(3'b111, 1'b1, "R6 sweep next");
      end
    end

    // pseudo-random run against the model
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0], lfsr[7] | lfsr[9], "R4 R5 R6 random");
    end

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule